// File: doc/BRIEF.md
# Software Write-Protection Unlock Sequencer

This block watches the write strobes of a byte-wide memory bus and recognises fixed address/data command prefixes that switch an optional software write-protection mode on and off. While protection is off every write reaches the array. While protection is on, a write reaches the array only if the same burst opened with a three-write unlock prefix. A separate six-write sequence clears protection and requests a dummy write cycle.

The block sits between the bus decoder and the write sequencer. For each write it raises `wr_allow_o` in the same cycle when the write may be committed. It reports the mode on `protect_o` and pulses `dummy_cycle_o` when the clearing sequence completes. The write sequencer raises `burst_end_i` when a page-load window closes. That pulse aborts any partial prefix and withdraws the unlock. The matcher compares each write against the next expected step as the write arrives. Any mismatch sends it back to idle.

Top module: `wp_unlock_seq`

## Requirements
- R1: After reset `protect_o` and `dummy_cycle_o` are 0. While `protect_o` is 0, `wr_allow_o` equals `wr_valid_i` for every address and data value.
- R2: The writes 0xAA at 0x1555, 0x55 at 0x0AAA and 0xA0 at 0x1555, in that order, set `protect_o` to 1 in the cycle after the third write. With any other third data value at 0x1555, `protect_o` stays unchanged.
- R3: While protection is on and no unlock prefix has completed in the current burst, `wr_allow_o` is 0 for every write, including command writes.
- R4: After the unlock prefix completes, later writes in the same burst are allowed while they fall in the page row of the first such write. The row is address bits [12:6] with the default page width of 6. Writes to any other row are blocked.
- R5: A `burst_end_i` pulse withdraws the unlock. Writes after it are blocked until another unlock prefix completes.
- R6: A write that is not the expected next step returns the matcher to idle. A correct step that follows a wrong one does not complete any sequence.
- R7: The writes 0xAA at 0x1555, 0x55 at 0x0AAA, 0x80 at 0x1555, 0xAA at 0x1555, 0x55 at 0x0AAA and 0x20 at 0x1555 clear `protect_o` in the cycle after the sixth write. `dummy_cycle_o` is 1 for exactly that cycle.
- R8: The clearing sequence completes, and pulses `dummy_cycle_o`, whether or not protection was on.
- R9: A `burst_end_i` pulse in the middle of a prefix aborts the prefix. Finishing the steps after the pulse does not complete the sequence.
- R10: While an unlock is open, writes are page data and do not advance the matcher. A clearing sequence written inside an open unlock leaves protection on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | One write on the bus this cycle |
| wr_addr_i | input | 13 | Write address |
| wr_data_i | input | 8 | Write data |
| burst_end_i | input | 1 | Page-load window closed |
| wr_allow_o | output | 1 | This write may be committed to the array |
| protect_o | output | 1 | Software write protection is on |
| dummy_cycle_o | output | 1 | One-cycle request for a dummy write cycle after clearing |

## Verification
The bench builds the block with its defaults: a 13-bit address, 8-bit data and a 6-bit page offset, which gives 64-byte rows. With these values the bench can drive all 256 data values into the third prefix step and check which value enables, which one arms the clearing path and which ones abort. It can also write every offset of one row under an open unlock and then probe neighbouring rows. The command addresses and data values keep their default settings, so the bench derives every expected value directly from the step sequences.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int DIS_STEPS = 6;
  localparam int ENABLE_AT = 2;
  localparam int STEP_W    = $clog2(DIS_STEPS);
  typedef logic [STEP_W-1:0] step_t;
  typedef enum logic [1:0] {HIT_NONE, HIT_STEP, HIT_ENABLE} hit_e;
endpackage

// File: rtl/wp_step_match.sv
module wp_step_match
  import wp_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_A  = 'h1555,
  parameter logic [ADDR_W-1:0] ADDR_B  = 'h0AAA,
  parameter logic [DATA_W-1:0] D_FIRST = 'hAA,
  parameter logic [DATA_W-1:0] D_SECOND= 'h55,
  parameter logic [DATA_W-1:0] D_EN    = 'hA0,
  parameter logic [DATA_W-1:0] D_ARM   = 'h80,
  parameter logic [DATA_W-1:0] D_CLR   = 'h20
) (
  input  step_t             step_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output hit_e              hit_o
);
  logic [ADDR_W-1:0] exp_addr [DIS_STEPS];
  logic [DATA_W-1:0] exp_data [DIS_STEPS];

  // clearing path = two halves of three steps: first, second, then arm/clear
  for (genvar g = 0; g < DIS_STEPS; g++) begin : g_step
    localparam int PH = g % 3;
    assign exp_addr[g] = (PH == 1) ? ADDR_B : ADDR_A;
    assign exp_data[g] = (PH == 0) ? D_FIRST :
                         (PH == 1) ? D_SECOND :
                         (g == 2)  ? D_ARM : D_CLR;
  end

  always_comb begin
    hit_o = HIT_NONE;
    if (step_i == step_t'(ENABLE_AT) && addr_i == ADDR_A && data_i == D_EN) begin
      hit_o = HIT_ENABLE;
    end else begin
      for (int k = 0; k < DIS_STEPS; k++) begin
        if (step_i == step_t'(k) && addr_i == exp_addr[k] && data_i == exp_data[k])
          hit_o = HIT_STEP;
      end
    end
  end
endmodule

// File: rtl/wp_seq_fsm.sv
module wp_seq_fsm
  import wp_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_valid_i,
  input  logic  burst_end_i,
  input  logic  hold_i,
  input  hit_e  hit_i,
  output step_t step_o,
  output logic  protect_o,
  output logic  dummy_o,
  output logic  unlock_set_o
);
  localparam step_t LAST = step_t'(DIS_STEPS - 1);

  step_t step_q;
  logic  prot_q, dummy_q;
  logic  take;

  assign take         = wr_valid_i && !hold_i && !burst_end_i;
  assign unlock_set_o = take && (hit_i == HIT_ENABLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q  <= '0;
      prot_q  <= 1'b0;
      dummy_q <= 1'b0;
    end else begin
      dummy_q <= 1'b0;
      if (burst_end_i) begin
        step_q <= '0;
      end else if (take) begin
        unique case (hit_i)
          HIT_ENABLE: begin
            prot_q <= 1'b1;
            step_q <= '0;
          end
          HIT_STEP: begin
            if (step_q == LAST) begin
              prot_q  <= 1'b0;
              dummy_q <= 1'b1;
              step_q  <= '0;
            end else begin
              step_q <= step_q + step_t'(1);
            end
          end
          default: step_q <= '0;
        endcase
      end
    end
  end

  assign step_o    = step_q;
  assign protect_o = prot_q;
  assign dummy_o   = dummy_q;

  assert_step_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q <= LAST);
  assert_burst_abort_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_end_i |=> step_q == '0);
  assert_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !burst_end_i) |=> $stable(step_q) && $stable(prot_q));
endmodule

// File: rtl/wp_page_gate.sv
module wp_page_gate #(
  parameter int ROW_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             protect_i,
  input  logic             unlock_set_i,
  input  logic             burst_end_i,
  output logic             unlocked_o,
  output logic             allow_o
);
  logic             unlocked_q, row_vld_q;
  logic [ROW_W-1:0] row_q;
  logic             row_ok;

  assign row_ok  = !row_vld_q || (row_q == row_i);
  assign allow_o = wr_valid_i && (!protect_i || (unlocked_q && row_ok));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlocked_q <= 1'b0;
      row_vld_q  <= 1'b0;
      row_q      <= '0;
    end else if (burst_end_i) begin
      unlocked_q <= 1'b0;
      row_vld_q  <= 1'b0;
    end else if (unlock_set_i) begin
      unlocked_q <= 1'b1;
      row_vld_q  <= 1'b0;
    end else if (wr_valid_i && unlocked_q && !row_vld_q) begin
      row_q     <= row_i;
      row_vld_q <= 1'b1;
    end
  end

  assign unlocked_o = unlocked_q;

  assert_locked_block_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (protect_i && !unlocked_q) |-> !allow_o);
  assert_unlock_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_end_i |=> !unlocked_q);
  assert_row_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_vld_q && !burst_end_i && !unlock_set_i) |=> $stable(row_q));
endmodule

// File: rtl/wp_unlock_seq.sv
module wp_unlock_seq
  import wp_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 6,
  parameter logic [ADDR_W-1:0] ADDR_A = 'h1555,
  parameter logic [ADDR_W-1:0] ADDR_B = 'h0AAA,
  parameter logic [DATA_W-1:0] D_EN   = 'hA0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              burst_end_i,
  output logic              wr_allow_o,
  output logic              protect_o,
  output logic              dummy_cycle_o
);
  localparam int ROW_W = ADDR_W - PAGE_W;

  step_t step;
  hit_e  hit;
  logic  unlocked, unlock_set;

  wp_step_match #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .ADDR_A(ADDR_A), .ADDR_B(ADDR_B), .D_EN(D_EN)
  ) u_match (
    .step_i(step), .addr_i(wr_addr_i), .data_i(wr_data_i), .hit_o(hit)
  );

  wp_seq_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_valid_i(wr_valid_i),
    .burst_end_i(burst_end_i), .hold_i(unlocked), .hit_i(hit),
    .step_o(step), .protect_o(protect_o), .dummy_o(dummy_cycle_o),
    .unlock_set_o(unlock_set)
  );

  wp_page_gate #(.ROW_W(ROW_W)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_valid_i(wr_valid_i),
    .row_i(wr_addr_i[ADDR_W-1:PAGE_W]), .protect_i(protect_o),
    .unlock_set_i(unlock_set), .burst_end_i(burst_end_i),
    .unlocked_o(unlocked), .allow_o(wr_allow_o)
  );

  assert_allow_needs_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_allow_o |-> wr_valid_i);
  assert_enable_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(protect_o) |-> $past(wr_valid_i && wr_addr_i == ADDR_A && wr_data_i == D_EN));
  assert_dummy_on_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(protect_o) |-> dummy_cycle_o);
  assert_dummy_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dummy_cycle_o |=> !dummy_cycle_o);
endmodule

// File: tb/sim_wp_unlock_seq.sv
`timescale 1ns/1ps
module sim_wp_unlock_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [12:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        burst_end = 1'b0;
  logic        wr_allow, protect, dummy;
  int          checks = 0, failures = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  wp_unlock_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .burst_end_i(burst_end), .wr_allow_o(wr_allow),
    .protect_o(protect), .dummy_cycle_o(dummy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d, output logic al);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; burst_end = 1'b0;
    #1 al = wr_allow;
  endtask

  task automatic idle();
    @(negedge clk);
    wr_valid = 1'b0; burst_end = 1'b0;
    #1;
  endtask

  task automatic bend();
    @(negedge clk);
    wr_valid = 1'b0; burst_end = 1'b1;
    #1;
  endtask

  task automatic unlock_seq(input string req);
    logic al;
    wr(13'h1555, 8'hAA, al); wr(13'h0AAA, 8'h55, al); wr(13'h1555, 8'hA0, al);
  endtask

  task automatic clear_seq();
    logic al;
    wr(13'h1555, 8'hAA, al); wr(13'h0AAA, 8'h55, al); wr(13'h1555, 8'h80, al);
    wr(13'h1555, 8'hAA, al); wr(13'h0AAA, 8'h55, al); wr(13'h1555, 8'h20, al);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic al;
    repeat (3) @(negedge clk);
    #1;
    chk(protect == 1'b0, "R1 reset protect", protect, 0);
    chk(dummy == 1'b0, "R1 reset dummy", dummy, 0);
    @(negedge clk); rst_n = 1'b1;

    // R1: unprotected writes all pass
    for (int i = 0; i < 32; i++) begin
      wr(13'(i * 263), 8'(i * 7), al);
      chk(al == 1'b1, "R1 open write", al, 1);
    end
    idle();
    chk(wr_allow == 1'b0, "R1 no write no allow", wr_allow, 0);

    // R2/R6: sweep third step data
    for (int d = 0; d < 256; d++) begin
      wr(13'h1555, 8'hAA, al); wr(13'h0AAA, 8'h55, al); wr(13'h1555, 8'(d), al);
      idle();
      chk(protect == (d == 8'hA0), "R2 third step sweep", protect, int'(d == 8'hA0));
      bend();
      if (d == 8'hA0) begin
        clear_seq();
        idle();
        chk(protect == 1'b0, "R7 clear protect", protect, 0);
        chk(dummy == 1'b1, "R7 dummy pulse", dummy, 1);
        idle();
        chk(dummy == 1'b0, "R7 dummy one cycle", dummy, 0);
      end
    end

    // R3: protected, no unlock: everything blocked
    unlock_seq("R3"); bend();
    chk(protect == 1'b1, "R3 protect on", protect, 1);
    for (int i = 0; i < 16; i++) begin
      wr(13'(i * 511 + 3), 8'(i), al);
      chk(al == 1'b0, "R3 blocked write", al, 0);
    end
    wr(13'h1555, 8'hAA, al);
    chk(al == 1'b0, "R3 command write blocked", al, 0);
    bend();

    // R4: full row allowed after unlock, other rows blocked
    unlock_seq("R4");
    for (int o = 0; o < 64; o++) begin
      wr(13'h0100 + 13'(o), 8'(o ^ 8'h3C), al);
      chk(al == 1'b1, "R4 row write", al, 1);
    end
    wr(13'h0140, 8'h11, al);
    chk(al == 1'b0, "R4 next row blocked", al, 0);
    wr(13'h00FF, 8'h11, al);
    chk(al == 1'b0, "R4 prev row blocked", al, 0);
    wr(13'h013F, 8'h22, al);
    chk(al == 1'b1, "R4 back in row", al, 1);
    // R5: burst end withdraws unlock
    bend();
    wr(13'h0105, 8'h22, al);
    chk(al == 1'b0, "R5 after burst end", al, 0);
    bend();

    // R6: wrong step mid-prefix
    wr(13'h1555, 8'hAA, al); wr(13'h0AAA, 8'h55, al);
    wr(13'h1555, 8'h12, al); wr(13'h1555, 8'hA0, al);
    wr(13'h0100, 8'h01, al);
    chk(al == 1'b0, "R6 wrong step no unlock", al, 0);
    bend();
    wr(13'h1555, 8'hAA, al); wr(13'h0AAB, 8'h55, al); wr(13'h1555, 8'hA0, al);
    wr(13'h0100, 8'h01, al);
    chk(al == 1'b0, "R6 wrong address no unlock", al, 0);
    bend();
    unlock_seq("R6");
    wr(13'h0100, 8'h01, al);
    chk(al == 1'b1, "R6 restart works", al, 1);
    bend();

    // R6: wrong fourth step in clearing sequence
    wr(13'h1555, 8'hAA, al); wr(13'h0AAA, 8'h55, al); wr(13'h1555, 8'h80, al);
    wr(13'h1555, 8'hBB, al); wr(13'h0AAA, 8'h55, al); wr(13'h1555, 8'h20, al);
    idle();
    chk(protect == 1'b1, "R6 broken clear keeps protect", protect, 1);
    chk(dummy == 1'b0, "R6 broken clear no dummy", dummy, 0);
    bend();

    // R9: burst end inside prefix
    wr(13'h1555, 8'hAA, al); wr(13'h0AAA, 8'h55, al);
    bend();
    wr(13'h1555, 8'hA0, al);
    wr(13'h0100, 8'h01, al);
    chk(al == 1'b0, "R9 aborted prefix", al, 0);
    bend();
    wr(13'h1555, 8'hAA, al); wr(13'h0AAA, 8'h55, al); wr(13'h1555, 8'h80, al);
    wr(13'h1555, 8'hAA, al);
    bend();
    wr(13'h0AAA, 8'h55, al); wr(13'h1555, 8'h20, al);
    idle();
    chk(protect == 1'b1, "R9 aborted clear", protect, 1);
    bend();

    // R10: clearing sequence inside open unlock is data
    unlock_seq("R10");
    wr(13'h0100, 8'h01, al);
    clear_seq();
    idle();
    chk(protect == 1'b1, "R10 clear ignored while unlocked", protect, 1);
    chk(dummy == 1'b0, "R10 no dummy while unlocked", dummy, 0);
    bend();
    idle();
    chk(protect == 1'b1, "R10 protect after burst", protect, 1);

    // R7: real clear from protected
    clear_seq();
    idle();
    chk(protect == 1'b0, "R7 protect cleared", protect, 0);
    chk(dummy == 1'b1, "R7 dummy", dummy, 1);
    wr(13'h0777, 8'h5A, al);
    chk(al == 1'b1, "R1 open after clear", al, 1);

    // R8: clear while unprotected
    bend();
    clear_seq();
    idle();
    chk(dummy == 1'b1, "R8 dummy when unprotected", dummy, 1);
    chk(protect == 1'b0, "R8 protect stays off", protect, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule